// File: doc/BRIEF.md
# 10BASE-T Link Pulse Generator and Link Integrity Monitor

This block produces the idle-line link pulses of a 10BASE-T port and judges whether the far end is present. It runs on a 10 MHz clock. While the transmit-activity input is low, it raises a strobe that is one clock wide, which is 100 ns, once every pulse period. The pulse timer is cleared whenever transmit activity is seen, so the first idle pulse comes one full period after traffic stops.

On the receive side the block watches a strobe that marks each qualified incoming link pulse and another that marks each received packet. If neither strobe appears for a whole loss window, link-good drops and the transmit, receive and collision-detect enables are forced low. Link-good comes back after one received packet, or after two incoming link pulses with no expired loss window between them. A configuration input turns the integrity check off so that the link counts as good at all times. A loopback input keeps the transmit and receive paths enabled whatever the link state is. A speed-select input makes the link indicator follow an externally supplied 100 Mb/s link status in place of the 10 Mb/s result.

The pulse period and the loss window are parameters given in clock cycles. Simulation uses short values; silicon uses 160000 cycles (16 ms) and 1000000 cycles (100 ms).

Top module: `link_pulse_mon`

## Requirements
- R1: While reset is held and for the first cycle after it, link_good, link_ind, tx_enable, rx_enable, col_enable and lp_out are all 0, provided integrity_off, loopback and speed_100 are 0.
- R2: While tx_active stays 0, lp_out is high for exactly one cycle, and consecutive pulses are PERIOD_CYC cycles apart. The first pulse after reset appears PERIOD_CYC cycles after reset is released.
- R3: lp_out is 0 in every cycle that follows a cycle with tx_active at 1. After tx_active falls, the next pulse comes PERIOD_CYC cycles after the last cycle in which tx_active was high.
- R4: If link_good is up and LOSS_CYC consecutive cycles pass with rx_link_pulse and rx_packet both at 0, the link drops in the cycle after the last quiet cycle.
- R5: While the link is down, it is restored one cycle after the second of two rx_link_pulse strobes. A lone pulse followed by an expired loss window does not count toward the two.
- R6: While the link is down, a single rx_packet strobe restores it in the next cycle.
- R7: With integrity_off and loopback at 0, tx_enable, rx_enable and col_enable each equal link_good.
- R8: With integrity_off at 1, link_good, tx_enable, rx_enable and col_enable are 1 in the same cycle, whatever the monitored link state is.
- R9: With loopback at 1, tx_enable and rx_enable are 1 in the same cycle. col_enable still follows link_good.
- R10: link_ind equals hs_link_ok when speed_100 is 1 and equals link_good when speed_100 is 0.
- R11: Each rx_link_pulse or rx_packet strobe restarts the loss window, so the link survives any run of fewer than LOSS_CYC quiet cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | High while packet data is being transmitted |
| rx_link_pulse | input | 1 | One-cycle strobe for each qualified incoming link pulse |
| rx_packet | input | 1 | One-cycle strobe for each received packet |
| integrity_off | input | 1 | Disables the integrity check; the link is treated as good |
| loopback | input | 1 | Keeps the transmit and receive enables on regardless of the link |
| speed_100 | input | 1 | Selects the 100 Mb/s status for the link indicator |
| hs_link_ok | input | 1 | Link status supplied by the 100 Mb/s path |
| lp_out | output | 1 | Generated link pulse, one clock wide |
| link_good | output | 1 | 10 Mb/s link status after the integrity override |
| link_ind | output | 1 | Link indicator for the selected speed |
| tx_enable | output | 1 | Transmitter enable |
| rx_enable | output | 1 | Receiver enable |
| col_enable | output | 1 | Collision-detect enable |

## Verification
The assertions check on every cycle that pulses are one clock wide, that no pulse follows transmit activity, that a packet restores the link, that the link drops only after a quiet cycle, and that the overrides and the gating reach the enable outputs. Exact pulse spacing, the restart of the pulse timer after traffic, the length of the loss window, and the rule that an expired window cancels a lone pulse all depend on counts across many cycles. Only the bench's scenarios show those, by comparing every output on every cycle against a behavioural model.

// File: rtl/link_pulse_mon.sv
module link_pulse_mon #(
  parameter int PERIOD_CYC = 160000,
  parameter int LOSS_CYC   = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic rx_link_pulse,
  input  logic rx_packet,
  input  logic integrity_off,
  input  logic loopback,
  input  logic speed_100,
  input  logic hs_link_ok,
  output logic lp_out,
  output logic link_good,
  output logic link_ind,
  output logic tx_enable,
  output logic rx_enable,
  output logic col_enable
);
  localparam int PW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam int LW = (LOSS_CYC > 2) ? $clog2(LOSS_CYC) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PERIOD_CYC - 1);
  localparam logic [LW-1:0] L_LAST = LW'(LOSS_CYC - 1);

  logic [PW-1:0] ptmr;
  logic [LW-1:0] ltmr;
  logic          link_ok;
  logic          one_seen;
  logic          rx_act;
  logic          expired;

  assign rx_act  = rx_link_pulse | rx_packet;
  assign expired = !rx_act && (ltmr == L_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptmr   <= '0;
      lp_out <= 1'b0;
    end else if (tx_active) begin
      ptmr   <= '0;
      lp_out <= 1'b0;
    end else if (ptmr == P_LAST) begin
      ptmr   <= '0;
      lp_out <= 1'b1;
    end else begin
      ptmr   <= ptmr + 1'b1;
      lp_out <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ltmr <= '0;
    end else if (rx_act || expired) begin
      ltmr <= '0;
    end else begin
      ltmr <= ltmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_ok  <= 1'b0;
      one_seen <= 1'b0;
    end else if (rx_packet) begin
      link_ok  <= 1'b1;
      one_seen <= 1'b0;
    end else if (rx_link_pulse) begin
      if (link_ok) begin
        one_seen <= 1'b0;
      end else if (one_seen) begin
        link_ok  <= 1'b1;
        one_seen <= 1'b0;
      end else begin
        one_seen <= 1'b1;
      end
    end else if (expired) begin
      link_ok  <= 1'b0;
      one_seen <= 1'b0;
    end
  end

  assign link_good  = link_ok | integrity_off;
  assign link_ind   = speed_100 ? hs_link_ok : link_good;
  assign tx_enable  = link_good | loopback;
  assign rx_enable  = link_good | loopback;
  assign col_enable = link_good;

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lp_out |=> !lp_out);

  p_no_pulse_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> !lp_out);

  p_drop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ok) |-> $past(!rx_link_pulse && !rx_packet));

  p_pkt_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_packet |=> link_good);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!loopback && !col_enable) |-> (!tx_enable && !rx_enable));

  p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
    integrity_off |-> (tx_enable && rx_enable && col_enable));

  p_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> (tx_enable && rx_enable));

  p_ind_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_100 |-> (link_ind == col_enable));
endmodule

// File: tb/sim_link_pulse_mon.sv
module sim_link_pulse_mon;
  localparam int CLK_PERIOD = 100;
  localparam int P = 20;
  localparam int L = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0, rx_link_pulse = 1'b0, rx_packet = 1'b0;
  logic integrity_off = 1'b0, loopback = 1'b0, speed_100 = 1'b0, hs_link_ok = 1'b0;
  logic lp_out, link_good, link_ind, tx_enable, rx_enable, col_enable;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_idle = 0;
  int m_quiet = 0;
  int m_half = 0;
  bit m_ok = 0;
  bit m_lp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_pulse_mon #(.PERIOD_CYC(P), .LOSS_CYC(L)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
    .rx_link_pulse(rx_link_pulse), .rx_packet(rx_packet),
    .integrity_off(integrity_off), .loopback(loopback),
    .speed_100(speed_100), .hs_link_ok(hs_link_ok),
    .lp_out(lp_out), .link_good(link_good), .link_ind(link_ind),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .col_enable(col_enable));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_idle = 0; m_quiet = 0; m_half = 0; m_ok = 0; m_lp = 0;
    end else begin
      if (tx_active) begin
        m_idle = 0; m_lp = 0;
      end else begin
        m_idle++;
        m_lp = (m_idle == P);
        if (m_lp) m_idle = 0;
      end
      if (rx_packet) begin
        m_ok = 1; m_half = 0; m_quiet = 0;
      end else if (rx_link_pulse) begin
        m_quiet = 0;
        if (m_ok) m_half = 0;
        else if (m_half == 1) begin m_ok = 1; m_half = 0; end
        else m_half = 1;
      end else begin
        m_quiet++;
        if (m_quiet == L) begin m_quiet = 0; m_ok = 0; m_half = 0; end
      end
    end
  endtask

  task automatic compare();
    bit g;
    g = m_ok | integrity_off;
    chk("R2", "lp_out", lp_out, m_lp);
    chk("R4", "link_good", link_good, g);
    chk("R10", "link_ind", link_ind, speed_100 ? hs_link_ok : g);
    chk("R9", "tx_enable", tx_enable, g | loopback);
    chk("R9", "rx_enable", rx_enable, g | loopback);
    chk("R7", "col_enable", col_enable, g);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic strobe_pulse();
    rx_link_pulse = 1'b1; run(1); rx_link_pulse = 1'b0;
  endtask

  task automatic strobe_pkt();
    rx_packet = 1'b1; run(1); rx_packet = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    run(4);
    rst_n = 1'b1;
    run(1);
    chk("R1", "link_good after reset", link_good, 1'b0);
    // R2: idle pulses
    run(75);
    // R3: transmit suppresses and restarts pulses
    run(7);
    tx_active = 1'b1; run(30);
    tx_active = 1'b0; run(45);
    // R5: two pulses restore link; R7 gating follows
    strobe_pulse(); run(10); strobe_pulse(); run(3);
    chk("R5", "link restored by two pulses", link_good, 1'b1);
    // R11: activity restarts loss window
    run(40); strobe_pulse(); run(40); strobe_pkt(); run(45);
    chk("R11", "link held by activity", link_good, 1'b1);
    // R4: loss after quiet window
    run(10);
    chk("R4", "link lost", link_good, 1'b0);
    // R5: lone pulse cancelled by expired window
    strobe_pulse(); run(55); strobe_pulse(); run(3);
    chk("R5", "lone pulses do not restore", link_good, 1'b0);
    // R6: packet restores
    strobe_pkt(); run(2);
    chk("R6", "packet restores", link_good, 1'b1);
    run(60);
    // R8: integrity disable while down
    integrity_off = 1'b1; run(10);
    chk("R8", "col_enable forced", col_enable, 1'b1);
    integrity_off = 1'b0; run(3);
    // R9: loopback while down
    loopback = 1'b1; run(6);
    chk("R9", "col_enable not forced", col_enable, 1'b0);
    loopback = 1'b0; run(3);
    // R10: speed select
    speed_100 = 1'b1; hs_link_ok = 1'b1; run(4);
    hs_link_ok = 1'b0; run(4);
    speed_100 = 1'b0; hs_link_ok = 1'b1; run(4);
    // R3: tx during link up, then pulses again
    strobe_pkt(); tx_active = 1'b1; run(25); tx_active = 1'b0; run(25);
    finish_up();
  end
endmodule